// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives a bank of common-anode seven-segment digits whose segment lines are wired in parallel across every digit. Because all digits share the same segment lines, only one digit can show its own value at a time. The block takes one 4-bit code and one decimal-point flag per digit. It lights the digits one after another, quickly enough that the eye sees them all lit together.

A prescaler turns the system clock into a fixed dwell slot for each digit. A scan index steps through the digits in ascending order and wraps back to the first. While a digit's slot lasts, its common line is driven high and the segment lines carry its glyph. The segments are active low, and the decimal point follows that digit's flag. The last cycle of every slot is blank: no digit is enabled and all segments are off, so the previous digit's pattern cannot bleed into the next one. All outputs come from registers.

The slot length is `CLK_HZ / (REFRESH_HZ * NUM_DIGITS)` clock cycles. With the defaults (50 MHz, 1 kHz, four digits) this is 12500 cycles.

Top module: `disp_scan`

## Requirements
- R1: During any clock edge with `rst_n` low, the outputs become blank on that edge (`dig_en` all 0, `seg_n` all 1), and the scan restarts at digit 0.
- R2: At most one bit of `dig_en` is high in any cycle.
- R3: After reset is released, the digits are enabled in the order 0, 1, …, NUM_DIGITS-1, and the order then repeats. Bit i of `dig_en` enables digit i.
- R4: Each slot ends with exactly one blank cycle, in which `dig_en` is all 0 and `seg_n` is all 1. `seg_n` is all 1 whenever `dig_en` is all 0.
- R5: Segment bit positions in `seg_n` are a=0, b=1, c=2, d=3, e=4, f=5, g=6, dp=7, all active low. Codes 0–9 light these segments (as a 7-bit active-high value with bit 0 = a): 0→0x3F, 1→0x06, 2→0x5B, 3→0x4F, 4→0x66, 5→0x6D, 6→0x7D, 7→0x07, 8→0x7F, 9→0x6F.
- R6: Codes 10–15 light these segments (same encoding as R5): A→0x77, b→0x7C, C→0x39, d→0x5E, E→0x79, F→0x71.
- R7: `seg_n[7]` is low exactly when the enabled digit's `dp_flag` bit is 1.
- R8: Each slot lasts DWELL = CLK_HZ/(REFRESH_HZ*NUM_DIGITS) cycles. A digit is lit for DWELL-1 consecutive cycles, followed by the one blank cycle. The first lit cycle comes one clock edge after reset is released.
- R9: Outputs have one cycle of latency. A code or flag change seen at a clock edge appears on `seg_n` right after that edge, even in the middle of a slot. Digit i's code is `digit_code[4*i+3:4*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| digit_code | input | 4*NUM_DIGITS | Packed hex codes, digit i at bits 4i+3..4i |
| dp_flag | input | NUM_DIGITS | Decimal point request per digit |
| dig_en | output | NUM_DIGITS | Active-high common-anode digit enables |
| seg_n | output | 8 | Active-low segments, a at bit 0 through dp at bit 7 |

## Verification
The bench builds the block with four digits, CLK_HZ=32 and REFRESH_HZ=2, so each slot is four cycles and a full frame takes sixteen. This short frame lets every cycle be compared against an arithmetic model of the slot and phase. All sixteen codes can be held on every digit position, and every decimal-point pattern can be exercised within a few hundred cycles. A later phase changes the inputs on every cycle to expose the one-cycle latency. A reset is asserted mid-frame to confirm that the scan restarts.

// File: rtl/disp_scan_pkg.sv
// Package: shared constants for the display scanner.
// Assumes: segment vector layout a..g at bits 0..6, dp at bit 7.
package disp_scan_pkg;
    localparam int SEG_W   = 8;
    localparam int CODE_W  = 4;
    localparam int DP_BIT  = 7;
    typedef logic [SEG_W-1:0] seg_vec_t;
    localparam seg_vec_t SEG_ALL_OFF = '1;
endpackage

// File: rtl/scan_prescale.sv
// Module: scan_prescale
// Produces a one-cycle pulse every DWELL cycles; the pulse marks the last
// cycle of the current digit slot. Assumes DWELL >= 2.
module scan_prescale #(
    parameter int DWELL = 12500
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_end
);
    localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: count clock cycles within one slot, wrapping at DWELL.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: flag the final cycle of the slot.
    always_comb begin
        slot_end = (cnt_q == LAST);
    end
endmodule

// File: rtl/scan_sequencer.sv
// Module: scan_sequencer
// Holds the index of the digit being shown; steps to the next digit on
// each slot end and wraps after the last. Assumes NUM_DIGITS >= 2.
module scan_sequencer #(
    parameter int NUM_DIGITS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          advance,
    output logic [$clog2(NUM_DIGITS)-1:0] idx
);
    localparam int IW = $clog2(NUM_DIGITS);
    localparam logic [IW-1:0] TOP = IW'(NUM_DIGITS - 1);

    logic [IW-1:0] idx_q;

    // Purpose: rotate the digit index 0,1,..,N-1,0 on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (advance)
            idx_q <= (idx_q == TOP) ? '0 : idx_q + 1'b1;
    end

    // Purpose: expose the current index.
    always_comb begin
        idx = idx_q;
    end
endmodule

// File: rtl/glyph_decode.sv
// Module: glyph_decode
// Maps a 4-bit hex code and a dp request to active-low segment drives.
// Purely combinational; assumes common-anode wiring (low = lit).
module glyph_decode
    import disp_scan_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              dp,
    output seg_vec_t          seg_n
);
    logic [6:0] lit;

    // Purpose: select the lit segments (active high, a at bit 0).
    always_comb begin
        case (code)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            default: lit = 7'h71;
        endcase
    end

    // Purpose: invert to active-low drives and append the decimal point.
    always_comb begin
        seg_n = {~dp, ~lit};
    end
endmodule

// File: rtl/disp_scan.sv
// Module: disp_scan (top)
// Time-multiplexes shared active-low segment lines over NUM_DIGITS
// common-anode digits. Each slot lasts DWELL cycles and ends with one blank
// cycle. Outputs are registered. Assumes CLK_HZ/(REFRESH_HZ*NUM_DIGITS) >= 2.
module disp_scan
    import disp_scan_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int CLK_HZ     = 50_000_000,
    parameter int REFRESH_HZ = 1000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CODE_W*NUM_DIGITS-1:0] digit_code,
    input  logic [NUM_DIGITS-1:0]        dp_flag,
    output logic [NUM_DIGITS-1:0]        dig_en,
    output logic [SEG_W-1:0]             seg_n
);
    localparam int DWELL = CLK_HZ / (REFRESH_HZ * NUM_DIGITS);
    localparam int IW    = $clog2(NUM_DIGITS);

    logic                  slot_end;
    logic [IW-1:0]         idx;
    logic [CODE_W-1:0]     code_sel [NUM_DIGITS];
    logic [CODE_W-1:0]     cur_code;
    logic                  cur_dp;
    seg_vec_t              cur_seg_n;
    logic [NUM_DIGITS-1:0] en_next;
    logic [NUM_DIGITS-1:0] dig_en_q;
    seg_vec_t              seg_n_q;

    scan_prescale #(.DWELL(DWELL)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_end (slot_end)
    );

    scan_sequencer #(.NUM_DIGITS(NUM_DIGITS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (slot_end),
        .idx     (idx)
    );

    // Split the packed code bus into one lane per digit.
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_lane
        assign code_sel[g] = digit_code[CODE_W*g +: CODE_W];
    end

    // Purpose: pick the code, flag and one-hot enable of the active digit.
    always_comb begin
        cur_code = code_sel[idx];
        cur_dp   = dp_flag[idx];
        en_next  = '0;
        en_next[idx] = 1'b1;
    end

    glyph_decode u_dec (
        .code  (cur_code),
        .dp    (cur_dp),
        .seg_n (cur_seg_n)
    );

    // Purpose: register the pins; blank during reset and the slot's last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || slot_end) begin
            dig_en_q <= '0;
            seg_n_q  <= SEG_ALL_OFF;
        end else begin
            dig_en_q <= en_next;
            seg_n_q  <= cur_seg_n;
        end
    end

    // Purpose: drive the outputs from the registers.
    always_comb begin
        dig_en = dig_en_q;
        seg_n  = seg_n_q;
    end
endmodule

// File: rtl/disp_scan_chk.sv
// Module: disp_scan_chk
// Property checker for disp_scan, attached with bind below. It observes the
// output pins only and keeps its own record of the last enabled digit and
// the length of the current lit run.
module disp_scan_chk #(
    parameter int NUM_DIGITS = 4,
    parameter int DWELL      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_DIGITS-1:0] dig_en,
    input logic [7:0]            seg_n
);
    logic [NUM_DIGITS-1:0] last_q;
    int unsigned           run_q;

    // Purpose: remember the most recent non-blank enable pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (dig_en != '0)
            last_q <= dig_en;
    end

    // Purpose: count consecutive lit cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 0;
        else if (dig_en != '0)
            run_q <= run_q + 1;
        else
            run_q <= 0;
    end

    a_r1_reset_blanks: assert property (@(posedge clk)
        !rst_n |=> (dig_en == '0 && seg_n == 8'hFF));

    a_r2_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dig_en));

    a_r3_rotation: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en != '0 && $past(dig_en) == '0 && last_q != '0)
        |-> dig_en == {last_q[NUM_DIGITS-2:0], last_q[NUM_DIGITS-1]});

    a_r3_steady_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en != '0 && $past(dig_en) != '0) |-> $stable(dig_en));

    a_r4_blank_segments: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en == '0) |-> seg_n == 8'hFF);

    a_r8_lit_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en == '0 && run_q != 0) |-> run_q == DWELL - 1);
endmodule

bind disp_scan disp_scan_chk #(.NUM_DIGITS(NUM_DIGITS), .DWELL(DWELL)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dig_en (dig_en),
    .seg_n  (seg_n)
);

// File: tb/sim_disp_scan.sv
// Bench for disp_scan: four digits with a 4-cycle slot. Every cycle is
// compared against an arithmetic model of the slot and phase.
module sim_disp_scan;
    localparam int N  = 4;
    localparam int CK = 32;
    localparam int RF = 2;
    localparam int D  = CK / (RF * N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4*N-1:0] digit_code = '0;
    logic [N-1:0]   dp_flag = '0;
    logic [N-1:0]   dig_en;
    logic [7:0]     seg_n;

    int total = 0;
    int bad = 0;
    int k = 0;
    int cycles = 0;
    logic done = 1'b0;

    disp_scan #(.NUM_DIGITS(N), .CLK_HZ(CK), .REFRESH_HZ(RF)) u0 (
        .clk(clk), .rst_n(rst_n), .digit_code(digit_code),
        .dp_flag(dp_flag), .dig_en(dig_en), .seg_n(seg_n)
    );

    always #4 clk = ~clk;

    // Model: edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
        cycles <= cycles + 1;
    end

    function automatic logic [6:0] glyph(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;
            4'd2: return 7'h5B;  4'd3: return 7'h4F;
            4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;
            4'd8: return 7'h7F;  4'd9: return 7'h6F;
            4'd10: return 7'h77; 4'd11: return 7'h7C;
            4'd12: return 7'h39; 4'd13: return 7'h5E;
            4'd14: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (k=%0d)", req, act, exp, k);
        end
    endtask

    // Compare pins against the model; called at negedge before inputs change.
    task automatic check_now(input bit in_reset);
        int p, d;
        logic [3:0] c;
        if (in_reset || k == 0) begin
            chk("R1 en", dig_en, 0);
            chk("R1 seg", seg_n, 8'hFF);
            return;
        end
        p = (k - 1) % D;
        d = ((k - 1) / D) % N;
        if (p == D - 1) begin
            chk("R4 en", dig_en, 0);
            chk("R4 seg", seg_n, 8'hFF);
        end else begin
            c = digit_code[4*d +: 4];
            chk("R3 R8 en", dig_en, 1 << d);
            if (c < 10) chk("R5 R9 seg", seg_n[6:0], ~glyph(c) & 7'h7F);
            else        chk("R6 R9 seg", seg_n[6:0], ~glyph(c) & 7'h7F);
            chk("R7 dp", seg_n[7], !dp_flag[d]);
        end
        chk("R2 onehot", $countones(dig_en) <= 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_now(1);
        rst_n = 1'b1;
        // Phase A: every code on every position, dp patterns swept.
        for (int base = 0; base < 16; base++) begin
            for (int i = 0; i < N; i++)
                digit_code[4*i +: 4] = 4'((base + 5*i) % 16);
            dp_flag = 4'(base);
            for (int t = 0; t < N*D; t++) begin
                @(negedge clk);
                check_now(0);
            end
        end
        // Phase B: inputs change every cycle, mid-slot (R9).
        for (int t = 0; t < 300; t++) begin
            digit_code = 16'((t * 40503 + 7) & 16'hFFFF);
            dp_flag    = 4'((t * 3) % 16);
            @(negedge clk);
            check_now(0);
        end
        // Phase C: reset mid-frame, then scan restarts at digit 0 (R1).
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_now(1);
        rst_n = 1'b1;
        for (int t = 0; t < 3*N*D; t++) begin
            @(negedge clk);
            check_now(0);
        end
        done = 1'b1;
    end

    initial begin
        wait (done || cycles > 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule